// File: doc/BRIEF.md
# Interrupt Nesting Tracker

This block sits between an interrupt priority selector and one processor core. It answers the core's acknowledge requests and completion (end-of-interrupt) requests. It keeps the identity and priority of the interrupt the core is running. For every source it also stores a back-link to the interrupt that source preempted, so handlers can nest to any depth. A priority of 0x100, one above the largest 8-bit value, stands for "nothing running".

An acknowledge takes the selector's current best candidate only if that candidate strictly beats the running priority. When it does, the block emits a pending-clear strobe for that source. Completions do not have to arrive in nesting order. Completing the running interrupt pops back to its back-link. Completing an interrupt buried deeper in the chain starts a multi-cycle search that unlinks it. While the search runs the block reports busy, and it takes no new requests. On every accepted completion, a level-sensitive source whose line is still asserted is flagged for re-pending.

Requests are levels held by the requester until the block takes them. The block takes a request on a rising clock edge at which it is not busy. Every result appears registered, one cycle after the edge that took the request.

Top module: `irq_nest_tracker`

## Requirements
- R1: An acknowledge fails when the candidate ID is 1023, when the candidate ID is not below NUM_SRC, or when its priority (zero-extended to 9 bits) is not strictly below the running priority. A failed acknowledge returns ack_id 1023, produces no pending-clear strobe and leaves the running ID and priority unchanged.
- R2: A successful acknowledge returns the candidate ID and pulses pclr_vld with pclr_id equal to that ID, both in the same cycle as ack_vld. The candidate becomes the running interrupt with the candidate's priority. The interrupt that was running before is kept as the new interrupt's back-link.
- R3: After reset run_id is 1023, run_prio is 0x100, busy is low and all strobes are low. At all times run_prio is 0x100 exactly when run_id is 1023. Otherwise run_prio is the priority the running interrupt had when it was acknowledged.
- R4: A completion whose ID is NUM_SRC or above, including 1023, is taken but has no effect on any output.
- R5: A completion taken while run_id is 1023 has no effect on any output.
- R6: Completing the running ID makes its back-link the running ID, with the priority stored for that back-link, or 0x100 if the back-link is 1023.
- R7: Completing a valid ID that is not running searches the chain from the running ID. The back-link that equals the completed ID is replaced by the completed ID's own back-link. The search stops at a back-link of 1023 with nothing changed. The running ID and priority are not altered.
- R8: busy is high for each cycle of a chain search. Neither acknowledge nor completion is taken while busy is high. A request held across the search is taken at the first edge after busy falls.
- R9: When a completion passes the R4 and R5 filters, rp_vld pulses one cycle later with rp_id set to that ID, if and only if the source is level-sensitive (src_edge bit 0), enabled (src_en bit 1), targets this core (src_tgt bit 1) and has its line high (src_line bit 1).
- R10: When acknowledge and completion are requested at the same edge, the completion is taken and the acknowledge waits for the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hp_id | input | 10 | Highest-pending candidate ID from the selector |
| hp_prio | input | 8 | Priority of the candidate (lower is more urgent) |
| ack_req | input | 1 | Acknowledge request, held until ack_vld |
| eoi_req | input | 1 | Completion request |
| eoi_id | input | 10 | ID being completed |
| src_line | input | NUM_SRC | Current level of each source line |
| src_edge | input | NUM_SRC | 1 = edge-triggered, 0 = level-sensitive |
| src_en | input | NUM_SRC | Source enabled |
| src_tgt | input | NUM_SRC | Source targets this core |
| ack_vld | output | 1 | Acknowledge answer strobe |
| ack_id | output | 10 | Acknowledged ID, or 1023 on failure |
| pclr_vld | output | 1 | Clear-pending strobe |
| pclr_id | output | 10 | ID whose pending state is cleared |
| run_id | output | 10 | Running interrupt ID, 1023 when none |
| run_prio | output | 9 | Running priority, 0x100 when none |
| busy | output | 1 | Chain search in progress |
| rp_vld | output | 1 | Re-pend strobe for a still-asserted level source |
| rp_id | output | 10 | ID to re-pend |

## Verification
The bench goes after the strict-less-than comparison. An equal priority must be refused, so a design using less-or-equal would accept a candidate it should reject and emit a stray pending-clear. It completes interrupts in three orders: middle of the chain, bottom of a four-deep chain, and an ID not in the chain at all. A search that stopped early, wrote the wrong back-link or touched the running ID shows up as the wrong ID and priority on the later pops. It also holds an acknowledge across a search and raises both requests in one cycle, which catches a design that serves requests while busy or gives the acknowledge precedence. Finally, it checks the re-pend strobe against edge-triggered, disabled and idle-core completions, which catches a design that re-pends without testing all four conditions.

// File: rtl/ant_pkg.sv
package ant_pkg;
    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;
    localparam int RP_W   = PRIO_W + 1;

    typedef logic [ID_W-1:0]   id_t;
    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [RP_W-1:0]   rprio_t;

    // spurious / "none" identifier and the idle running priority
    localparam id_t    NONE_ID = '1;
    localparam rprio_t RP_NONE = rprio_t'(1) << PRIO_W;

    typedef enum logic {WS_IDLE, WS_SCAN} walk_st_e;
endpackage

// File: rtl/ant_link_store.sv
// Per-source back-link and captured priority storage.
module ant_link_store
    import ant_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int DEPTH  = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             we_pri,
    input  logic [IDX_W-1:0] wa,
    input  id_t              wlink,
    input  prio_t            wpri,
    input  logic [IDX_W-1:0] ra0,
    input  logic [IDX_W-1:0] ra1,
    input  logic [IDX_W-1:0] rap,
    output id_t              rlink0,
    output id_t              rlink1,
    output prio_t            rpri
);
    id_t   link_q [DEPTH];
    prio_t pri_q  [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                link_q[i] <= NONE_ID;
                pri_q[i]  <= '0;
            end
        end else if (we) begin
            link_q[wa] <= wlink;
            if (we_pri) pri_q[wa] <= wpri;
        end
    end

    assign rlink0 = link_q[ra0];
    assign rlink1 = link_q[ra1];
    assign rpri   = pri_q[rap];
endmodule

// File: rtl/ant_chain_walk.sv
// Multi-cycle search that unlinks a completed interrupt from inside the chain.
module ant_chain_walk
    import ant_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int SW     = $clog2(NUM_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_cur,
    input  logic [IDX_W-1:0] start_tgt,
    input  id_t              cur_link,
    input  id_t              tgt_link,
    output logic             busy,
    output logic [IDX_W-1:0] cur_addr,
    output logic [IDX_W-1:0] tgt_addr,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_addr,
    output id_t              wr_link
);
    localparam logic [SW-1:0] LAST_STEP = SW'(NUM_SRC - 1);

    typedef struct packed {
        walk_st_e         st;
        logic [IDX_W-1:0] cur;
        logic [IDX_W-1:0] tgt;
        logic [SW-1:0]    steps;
    } wst_t;

    wst_t q, d;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_addr = q.cur;
        wr_link = tgt_link;
        case (q.st)
            WS_IDLE: begin
                if (start) begin
                    d.st    = WS_SCAN;
                    d.cur   = start_cur;
                    d.tgt   = start_tgt;
                    d.steps = '0;
                end
            end
            WS_SCAN: begin
                if (cur_link == NONE_ID) begin
                    d.st = WS_IDLE;                     // end of chain, not found
                end else if (cur_link == id_t'(q.tgt)) begin
                    wr_en = 1'b1;                       // splice around target
                    d.st  = WS_IDLE;
                end else if (q.steps == LAST_STEP) begin
                    d.st = WS_IDLE;                     // bounded walk
                end else begin
                    d.cur   = cur_link[IDX_W-1:0];
                    d.steps = q.steps + 1'b1;
                end
            end
            default: d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= WS_IDLE;
            q.cur   <= '0;
            q.tgt   <= '0;
            q.steps <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st == WS_SCAN);
    assign cur_addr = q.cur;
    assign tgt_addr = q.tgt;

    p_walk_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q.steps < SW'(NUM_SRC)));
    p_walk_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/ant_repend.sv
// Re-pend decision for level-sensitive sources still asserted at completion.
module ant_repend
    import ant_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  id_t                cid,
    input  logic [NUM_SRC-1:0] src_line,
    input  logic [NUM_SRC-1:0] src_edge,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] src_tgt,
    output logic               rp_vld,
    output id_t                rp_id
);
    typedef struct packed {
        logic vld;
        id_t  id;
    } rp_t;

    rp_t q, d;
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx   = cid[IDX_W-1:0];
        d     = q;
        d.vld = take && !src_edge[idx] && src_en[idx] && src_tgt[idx] && src_line[idx];
        if (d.vld) d.id = cid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.vld <= 1'b0;
            q.id  <= NONE_ID;
        end else begin
            q <= d;
        end
    end

    assign rp_vld = q.vld;
    assign rp_id  = q.id;

    p_rp_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rp_vld |-> (rp_id < id_t'(NUM_SRC)));
endmodule

// File: rtl/irq_nest_tracker.sv
module irq_nest_tracker
    import ant_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [9:0]         hp_id,
    input  logic [7:0]         hp_prio,
    input  logic               ack_req,
    input  logic               eoi_req,
    input  logic [9:0]         eoi_id,
    input  logic [NUM_SRC-1:0] src_line,
    input  logic [NUM_SRC-1:0] src_edge,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] src_tgt,
    output logic               ack_vld,
    output logic [9:0]         ack_id,
    output logic               pclr_vld,
    output logic [9:0]         pclr_id,
    output logic [9:0]         run_id,
    output logic [8:0]         run_prio,
    output logic               busy,
    output logic               rp_vld,
    output logic [9:0]         rp_id
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        id_t    run_id;
        rprio_t run_prio;
        logic   ack_vld;
        id_t    ack_id;
        logic   pclr_vld;
        id_t    pclr_id;
    } trk_t;

    trk_t q, d;

    // request qualification
    logic eoi_take, ack_take, eoi_ok, eoi_run, walk_start, ack_ok;
    // storage and walker wiring
    logic             walk_busy, walk_we;
    logic [IDX_W-1:0] walk_cur, walk_tgt, walk_wa;
    id_t              walk_wl;
    logic             st_we, st_wpri;
    logic [IDX_W-1:0] st_wa, st_ra0;
    id_t              st_wl, rd_link0, rd_link1;
    prio_t            rd_pri;

    always_comb begin
        eoi_take   = eoi_req && !walk_busy;
        ack_take   = ack_req && !walk_busy && !eoi_req;
        eoi_ok     = eoi_take && (eoi_id < id_t'(NUM_SRC)) && (q.run_id != NONE_ID);
        eoi_run    = eoi_ok && (eoi_id == q.run_id);
        walk_start = eoi_ok && !eoi_run;
        ack_ok     = ack_take && (hp_id != NONE_ID) && (hp_id < id_t'(NUM_SRC))
                     && ({1'b0, hp_prio} < q.run_prio);

        d          = q;
        d.ack_vld  = 1'b0;
        d.pclr_vld = 1'b0;
        if (eoi_run) begin
            d.run_id   = rd_link0;
            d.run_prio = (rd_link0 == NONE_ID) ? RP_NONE : {1'b0, rd_pri};
        end else if (ack_take) begin
            d.ack_vld = 1'b1;
            if (ack_ok) begin
                d.ack_id   = hp_id;
                d.pclr_vld = 1'b1;
                d.pclr_id  = hp_id;
                d.run_id   = hp_id;
                d.run_prio = {1'b0, hp_prio};
            end else begin
                d.ack_id = NONE_ID;
            end
        end

        // storage port muxing: walker and acknowledge never write together
        st_we   = walk_we || ack_ok;
        st_wpri = !walk_we;
        st_wa   = walk_we ? walk_wa : hp_id[IDX_W-1:0];
        st_wl   = walk_we ? walk_wl : q.run_id;
        st_ra0  = walk_busy ? walk_cur : q.run_id[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.run_id   <= NONE_ID;
            q.run_prio <= RP_NONE;
            q.ack_vld  <= 1'b0;
            q.ack_id   <= NONE_ID;
            q.pclr_vld <= 1'b0;
            q.pclr_id  <= NONE_ID;
        end else begin
            q <= d;
        end
    end

    ant_link_store #(.NUM_SRC(NUM_SRC)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (st_we),
        .we_pri (st_wpri),
        .wa     (st_wa),
        .wlink  (st_wl),
        .wpri   (hp_prio),
        .ra0    (st_ra0),
        .ra1    (walk_tgt),
        .rap    (rd_link0[IDX_W-1:0]),
        .rlink0 (rd_link0),
        .rlink1 (rd_link1),
        .rpri   (rd_pri)
    );

    ant_chain_walk #(.NUM_SRC(NUM_SRC)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (walk_start),
        .start_cur (q.run_id[IDX_W-1:0]),
        .start_tgt (eoi_id[IDX_W-1:0]),
        .cur_link  (rd_link0),
        .tgt_link  (rd_link1),
        .busy      (walk_busy),
        .cur_addr  (walk_cur),
        .tgt_addr  (walk_tgt),
        .wr_en     (walk_we),
        .wr_addr   (walk_wa),
        .wr_link   (walk_wl)
    );

    ant_repend #(.NUM_SRC(NUM_SRC)) u_repend (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (eoi_ok),
        .cid      (eoi_id),
        .src_line (src_line),
        .src_edge (src_edge),
        .src_en   (src_en),
        .src_tgt  (src_tgt),
        .rp_vld   (rp_vld),
        .rp_id    (rp_id)
    );

    assign ack_vld  = q.ack_vld;
    assign ack_id   = q.ack_id;
    assign pclr_vld = q.pclr_vld;
    assign pclr_id  = q.pclr_id;
    assign run_id   = q.run_id;
    assign run_prio = q.run_prio;
    assign busy     = walk_busy;

    p_fail_noclear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && ack_id == NONE_ID) |-> !pclr_vld);
    p_pclr_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pclr_vld |-> (ack_vld && pclr_id == ack_id && run_id == ack_id));
    p_preempt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && ack_id != NONE_ID) |-> (run_prio < $past(run_prio)));
    p_idle_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id == NONE_ID) == (run_prio == RP_NONE));
    p_eoi_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !busy && eoi_id >= id_t'(NUM_SRC)) |=>
        (run_id == $past(run_id) && !busy && !rp_vld));
    p_eoi_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !busy && run_id == NONE_ID) |=>
        (run_id == NONE_ID && !busy && !rp_vld));
    p_walk_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (run_id == $past(run_id)));
    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !ack_vld);
    p_eoi_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && ack_req && !busy) |=> !ack_vld);
endmodule

// File: tb/tb_irq_nest_tracker.sv
`timescale 1ns/1ps
module tb_irq_nest_tracker;
    localparam int NS = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [9:0]    hp_id = 10'd1023;
    logic [7:0]    hp_prio = 8'd0;
    logic          ack_req = 1'b0;
    logic          eoi_req = 1'b0;
    logic [9:0]    eoi_id = 10'd0;
    logic [NS-1:0] src_line = '0, src_edge = '0, src_en = '0, src_tgt = '0;
    logic          ack_vld, pclr_vld, busy, rp_vld;
    logic [9:0]    ack_id, pclr_id, run_id, rp_id;
    logic [8:0]    run_prio;

    int n_chk = 0;
    int n_bad = 0;

    logic [9:0] g_ack, g_pclr_id, g_rp_id;
    logic       g_pclr_v, g_rp_v, g_busy;
    int         g_waits;

    always #2.5 clk = ~clk;

    irq_nest_tracker #(.NUM_SRC(NS)) dut (
        .clk(clk), .rst_n(rst_n), .hp_id(hp_id), .hp_prio(hp_prio),
        .ack_req(ack_req), .eoi_req(eoi_req), .eoi_id(eoi_id),
        .src_line(src_line), .src_edge(src_edge), .src_en(src_en), .src_tgt(src_tgt),
        .ack_vld(ack_vld), .ack_id(ack_id), .pclr_vld(pclr_vld), .pclr_id(pclr_id),
        .run_id(run_id), .run_prio(run_prio), .busy(busy),
        .rp_vld(rp_vld), .rp_id(rp_id)
    );

    typedef struct packed {
        logic       op;     // 0 = acknowledge, 1 = completion
        logic [9:0] id;
        logic [7:0] pr;
        logic [9:0] eack;
        logic [9:0] erid;
        logic [8:0] erp;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 10'd5,    8'h80, 10'd5,    10'd5,    9'h080},
        '{1'b0, 10'd7,    8'h80, 10'd1023, 10'd5,    9'h080},
        '{1'b0, 10'd9,    8'h40, 10'd9,    10'd9,    9'h040},
        '{1'b0, 10'd1023, 8'h00, 10'd1023, 10'd9,    9'h040},
        '{1'b0, 10'd12,   8'h10, 10'd12,   10'd12,   9'h010},
        '{1'b1, 10'd12,   8'h00, 10'd0,    10'd9,    9'h040},
        '{1'b1, 10'd9,    8'h00, 10'd0,    10'd5,    9'h080},
        '{1'b1, 10'd5,    8'h00, 10'd0,    10'd1023, 9'h100}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_ack(input logic [9:0] id, input logic [7:0] pr);
        @(negedge clk);
        hp_id = id; hp_prio = pr; ack_req = 1'b1;
        g_waits = 0;
        forever begin
            @(posedge clk); #1;
            if (ack_vld || g_waits > 50) break;
            g_waits++;
        end
        g_ack = ack_id; g_pclr_v = pclr_vld; g_pclr_id = pclr_id;
        ack_req = 1'b0;
    endtask

    task automatic do_eoi(input logic [9:0] id, input bit wait_done);
        @(negedge clk);
        eoi_id = id; eoi_req = 1'b1;
        @(posedge clk); #1;
        g_rp_v = rp_vld; g_rp_id = rp_id; g_busy = busy;
        eoi_req = 1'b0;
        if (wait_done) begin
            for (int k = 0; k < 200 && busy; k++) begin
                @(posedge clk); #1;
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R3 reset state
        chk("R3 reset run_id", run_id, 1023);
        chk("R3 reset run_prio", run_prio, 256);
        chk("R3 reset busy", busy, 0);
        chk("R3 reset strobes", {ack_vld, pclr_vld, rp_vld}, 0);

        // table walk: nesting, refusals (R1), preemption (R2), stack-order pops (R6)
        for (int v = 0; v < 8; v++) begin
            if (VEC[v].op == 1'b0) begin
                do_ack(VEC[v].id, VEC[v].pr);
                chk((VEC[v].eack == 10'd1023) ? "R1 ack id" : "R2 ack id", g_ack, VEC[v].eack);
                chk("R2 pclr strobe", g_pclr_v, (VEC[v].eack != 10'd1023));
                if (g_pclr_v) chk("R2 pclr id", g_pclr_id, VEC[v].eack);
            end else begin
                do_eoi(VEC[v].id, 1'b1);
                chk("R6 pop busy", g_busy, 0);
            end
            chk("R3 run_id", run_id, VEC[v].erid);
            chk("R3 run_prio", run_prio, VEC[v].erp);
        end

        // R1: candidate ID outside the implemented range
        do_ack(10'd70, 8'h01);
        chk("R1 out-of-range ack", g_ack, 1023);
        chk("R1 out-of-range pclr", g_pclr_v, 0);
        chk("R1 run unchanged", run_id, 1023);

        // R5: completion while idle, even with a level line high
        src_line[14] = 1'b1; src_en[14] = 1'b1; src_tgt[14] = 1'b1;
        do_eoi(10'd14, 1'b1);
        chk("R5 idle eoi repend", g_rp_v, 0);
        chk("R5 idle eoi busy", g_busy, 0);
        chk("R5 idle run_id", run_id, 1023);

        // chain 6 -> 4 -> 3
        do_ack(10'd3, 8'h90);
        do_ack(10'd4, 8'h60);
        do_ack(10'd6, 8'h30);
        chk("R2 nest run_id", run_id, 6);

        // R4: out-of-range and spurious completions ignored
        do_eoi(10'd1023, 1'b1);
        chk("R4 spurious busy", g_busy, 0);
        chk("R4 spurious run_id", run_id, 6);
        do_eoi(10'd64, 1'b1);
        chk("R4 range busy", g_busy, 0);
        chk("R4 range run_prio", run_prio, 9'h030);

        // R7 + R8: complete middle entry, acknowledge held across search
        do_eoi(10'd4, 1'b0);
        chk("R8 busy during walk", g_busy, 1);
        do_ack(10'd8, 8'h10);
        chk("R8 stall cycles", g_waits, 1);
        chk("R8 ack after stall", g_ack, 8);
        chk("R7 running kept", run_id, 8);
        do_eoi(10'd8, 1'b1);
        chk("R6 pop to 6", run_id, 6);
        chk("R6 prio of 6", run_prio, 9'h030);
        do_eoi(10'd6, 1'b1);
        chk("R7 unlinked 4 skipped", run_id, 3);
        chk("R7 prio of 3", run_prio, 9'h090);

        // R7: completion of an ID not in the chain
        do_eoi(10'd20, 1'b1);
        chk("R7 absent id run_id", run_id, 3);
        chk("R7 absent id run_prio", run_prio, 9'h090);
        do_eoi(10'd3, 1'b1);
        chk("R6 back to idle", run_id, 1023);

        // deep chain 10 -> 11 -> 13 -> 14, bottom completed first
        do_ack(10'd10, 8'hA0);
        do_ack(10'd11, 8'h70);
        do_ack(10'd13, 8'h50);
        do_ack(10'd14, 8'h20);
        src_line[10] = 1'b1; src_en[10] = 1'b1; src_tgt[10] = 1'b1; src_edge[10] = 1'b1;
        do_eoi(10'd10, 1'b1);
        chk("R9 edge source no repend", g_rp_v, 0);
        chk("R7 deep walk run_id", run_id, 14);
        do_eoi(10'd14, 1'b1);
        chk("R9 level repend vld", g_rp_v, 1);
        chk("R9 level repend id", g_rp_id, 14);
        chk("R6 deep pop 13", run_id, 13);
        chk("R6 deep prio 13", run_prio, 9'h050);
        do_eoi(10'd13, 1'b1);
        chk("R6 deep pop 11", run_id, 11);
        src_line[11] = 1'b1; src_tgt[11] = 1'b1; src_en[11] = 1'b0;
        do_eoi(10'd11, 1'b1);
        chk("R9 disabled no repend", g_rp_v, 0);
        chk("R7 unlinked bottom", run_id, 1023);
        chk("R3 idle prio", run_prio, 256);

        // R10: completion and acknowledge in the same cycle
        do_ack(10'd30, 8'h50);
        @(negedge clk);
        eoi_id = 10'd30; eoi_req = 1'b1;
        hp_id = 10'd31; hp_prio = 8'h60; ack_req = 1'b1;
        @(posedge clk); #1;
        chk("R10 ack deferred", ack_vld, 0);
        chk("R10 eoi first", run_id, 1023);
        eoi_req = 1'b0;
        @(posedge clk); #1;
        chk("R10 ack next cycle", ack_vld, 1);
        chk("R10 ack id", ack_id, 31);
        ack_req = 1'b0;
        do_eoi(10'd31, 1'b1);
        chk("R6 final idle", run_id, 1023);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule